// File: doc/BRIEF.md
# Multi-Table Cuckoo Key-Value Store

This block keeps key/value pairs in on-chip RAM split into several equal tables. Every table is indexed by its own hash of the key, so any key can sit in exactly one slot per table. A lookup reads all tables at once and picks the single matching entry. An insert of a new key goes into the first table without checking that slot first. The occupant that gets pushed out then moves to the next table in a fixed ring order, and so on, until a displaced slot turns out to be empty.

The requester presents one key per cycle with a command code and an optional value. Every accepted request returns a lookup result two cycles later. The result shows the contents as they were before the command took effect. While a modification or an eviction chain is in progress, the block raises a busy flag and ignores new requests. A chain that runs past a hop limit is abandoned: the last displaced entry is dropped and a sticky overflow flag is set.

Top module: `cuckoo_kv_store`

## Requirements
- R1: After synchronous reset every slot is empty. `busy`, `overflow` and `rsp_valid` read 0, and a lookup of any key misses.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. Exactly two cycles later `rsp_valid` pulses for one cycle. `rsp_hit` reports whether the key was stored, and `rsp_value` carries its value on a hit or 0 on a miss.
- R3: Lookups (`req_cmd` 0, and code 3, which acts the same) never raise `busy` and can be accepted on every cycle. They produce one response per cycle, in order.
- R4: `req_cmd` 2 with a key not yet stored writes the key into table 0. If that slot was empty, `busy` is high for exactly 2 cycles after acceptance and a later lookup returns the value.
- R5: When an insert displaces a valid entry from table t, that entry is written into table (t+1) mod 4 at its own hash there in the next cycle; table 3 wraps to table 0. Each hop adds one `busy` cycle (busy = 2 + hops). Every key stays findable and no key occupies two tables.
- R6: `req_cmd` 2 with a key already stored replaces its value in place, keeps `busy` high for 1 cycle and starts no chain.
- R7: `req_cmd` 1 removes the key if it is stored and does nothing otherwise. In both cases `busy` is high for 1 cycle.
- R8: Requests presented while `busy` is 1 are ignored. They produce no response and change no contents.
- R9: The response to a modifying request reports the contents before the modification.
- R10: A chain that has made HOP_LIMIT (default 24) hops and still displaces a valid entry stops. That entry is dropped, `busy` falls on the next cycle, and `overflow` becomes 1 and stays 1 until reset.
- R11: The slot index in table t is computed as follows. Take the key rotated left by t bits and XOR it with the low KEY_W bits of (t+1)*0x9E3779B97F4A7C15. Split the result into ADDR_W-bit chunks and XOR the chunks together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_key | input | KEY_W | Key to look up or modify |
| req_cmd | input | 2 | 0/3 lookup only, 1 delete, 2 insert or overwrite |
| req_value | input | VAL_W | Value for command 2 |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_hit | output | 1 | Key was present |
| rsp_value | output | VAL_W | Stored value on hit, 0 on miss |
| busy | output | 1 | Modification or eviction chain in progress; requests ignored |
| overflow | output | 1 | Sticky: an eviction chain was abandoned |

## Verification
A wrong slot index, a lost valid bit or a chain that writes the wrong table shows up as a wrong `rsp_hit` or `rsp_value` on the next lookup of an affected key. It also shows up as a `busy` pulse whose length differs from 2 plus the hop count, visible on the very insert that went wrong. The bench keeps a model of the four tables built only from the hash formula and the eviction order. It predicts, for every request, the response and the exact number of busy cycles, so a divergence is caught within the same request. Filling the store past its capacity exercises the wrap from the last table to the first, the hop limit and the dropped entry.

// File: rtl/cuckoo_pkg.sv
package cuckoo_pkg;

  typedef enum logic [1:0] {
    CMD_LOOK = 2'd0,
    CMD_DEL  = 2'd1,
    CMD_PUT  = 2'd2,
    CMD_RSV  = 2'd3
  } cmd_e;

  // Per-table salt: low bits of (t+1) times a fixed odd constant.
  function automatic logic [63:0] salt_of(input int tbl);
    return 64'(tbl + 1) * 64'h9E3779B97F4A7C15;
  endfunction

endpackage

// File: rtl/cuckoo_hash.sv
module cuckoo_hash #(
  parameter int KEY_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int TBL_IDX = 0
) (
  input  logic [KEY_W-1:0]  key,
  output logic [ADDR_W-1:0] idx
);
  localparam int ROT   = TBL_IDX % KEY_W;
  localparam int NCH   = (KEY_W + ADDR_W - 1) / ADDR_W;
  localparam int PAD_W = NCH * ADDR_W;
  localparam logic [63:0]      SALT64 = cuckoo_pkg::salt_of(TBL_IDX);
  localparam logic [KEY_W-1:0] SALT   = SALT64[KEY_W-1:0];

  logic [KEY_W-1:0] rotated;
  logic [PAD_W-1:0] padded;

  generate
    if (ROT == 0) begin : g_norot
      assign rotated = key;
    end else begin : g_rot
      assign rotated = {key[KEY_W-ROT-1:0], key[KEY_W-1:KEY_W-ROT]};
    end
  endgenerate

  assign padded = PAD_W'(rotated ^ SALT);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) idx ^= padded[i*ADDR_W +: ADDR_W];
  end
endmodule

// File: rtl/cuckoo_table.sv
module cuckoo_table #(
  parameter int KEY_W  = 16,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wr_vld,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [VAL_W-1:0]  wr_val,
  output logic              rd_vld,
  output logic [KEY_W-1:0]  rd_key,
  output logic [VAL_W-1:0]  rd_val
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ENT_W = KEY_W + VAL_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_ent;
  logic [DEPTH-1:0] occ;

  // Single-address RAM, read-first: the read returns the old occupant.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= {wr_key, wr_val};
    rd_ent <= mem[addr];
  end

  // Occupancy bits live in flops so reset empties the table at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (we) occ[addr] <= wr_vld;
      rd_vld <= occ[addr];
    end
  end

  assign rd_key = rd_ent[ENT_W-1:VAL_W];
  assign rd_val = rd_ent[VAL_W-1:0];
endmodule

// File: rtl/cuckoo_match.sv
module cuckoo_match #(
  parameter int NUM_TBL = 4,
  parameter int KEY_W   = 16,
  parameter int VAL_W   = 16
) (
  input  logic [NUM_TBL-1:0]            rd_vld,
  input  logic [NUM_TBL-1:0][KEY_W-1:0] rd_key,
  input  logic [NUM_TBL-1:0][VAL_W-1:0] rd_val,
  input  logic [KEY_W-1:0]              key,
  output logic [NUM_TBL-1:0]            hit_vec,
  output logic                          any_hit,
  output logic [VAL_W-1:0]              hit_val
);
  generate
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_cmp
      assign hit_vec[t] = rd_vld[t] && (rd_key[t] == key);
    end
  endgenerate

  assign any_hit = |hit_vec;

  always_comb begin
    hit_val = '0;
    for (int t = 0; t < NUM_TBL; t++)
      if (hit_vec[t]) hit_val |= rd_val[t];
  end
endmodule

// File: rtl/cuckoo_kv_store.sv
module cuckoo_kv_store #(
  parameter int NUM_TBL   = 4,
  parameter int KEY_W     = 16,
  parameter int VAL_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int HOP_LIMIT = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [1:0]       req_cmd,
  input  logic [VAL_W-1:0] req_value,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [VAL_W-1:0] rsp_value,
  output logic             busy,
  output logic             overflow
);
  import cuckoo_pkg::*;

  localparam int TBL_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;
  localparam int HOP_W = $clog2(HOP_LIMIT + 1);

  // Stage 1: request registered while the tables are read
  logic                           s1_valid;
  cmd_e                           s1_cmd;
  logic [KEY_W-1:0]               s1_key;
  logic [VAL_W-1:0]               s1_value;
  logic [NUM_TBL-1:0][ADDR_W-1:0] s1_addr;

  // Eviction chain state
  logic             chain_on;
  logic [TBL_W-1:0] chain_tbl;
  logic [HOP_W-1:0] chain_hops;
  logic             ovf_q;

  logic [NUM_TBL-1:0]            rd_vld;
  logic [NUM_TBL-1:0][KEY_W-1:0] rd_key;
  logic [NUM_TBL-1:0][VAL_W-1:0] rd_val;
  logic [NUM_TBL-1:0]            hit_vec;
  logic                          any_hit;
  logic [VAL_W-1:0]              hit_val;

  logic [NUM_TBL-1:0][ADDR_W-1:0] h_req;
  logic [NUM_TBL-1:0][ADDR_W-1:0] h_evc;

  logic             accept, s1_mod, s1_new_put;
  logic             disp_vld, hop_go, hop_stop;
  logic [TBL_W-1:0] next_tbl;

  assign s1_mod     = s1_valid && (s1_cmd == CMD_DEL || s1_cmd == CMD_PUT);
  assign busy       = s1_mod || chain_on;
  assign accept     = req_valid && !busy;
  assign s1_new_put = s1_valid && s1_cmd == CMD_PUT && !any_hit;

  assign next_tbl = (chain_tbl == TBL_W'(NUM_TBL - 1)) ? '0 : chain_tbl + 1'b1;
  assign disp_vld = chain_on && rd_vld[chain_tbl];
  assign hop_stop = disp_vld && (chain_hops == HOP_W'(HOP_LIMIT));
  assign hop_go   = disp_vld && !hop_stop;

  generate
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      localparam int PREV = (t == 0) ? NUM_TBL - 1 : t - 1;

      logic [ADDR_W-1:0] addr;
      logic              we, wr_vld, hop_here;
      logic [KEY_W-1:0]  wr_key;
      logic [VAL_W-1:0]  wr_val;

      cuckoo_hash #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .TBL_IDX(t)) i_hreq (
        .key(req_key), .idx(h_req[t]));
      cuckoo_hash #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .TBL_IDX(t)) i_hevc (
        .key(rd_key[PREV]), .idx(h_evc[t]));

      assign hop_here = hop_go && (next_tbl == TBL_W'(t));

      // Port steering: chain hop, then stage-1 modification, else new read
      always_comb begin
        addr   = h_req[t];
        we     = 1'b0;
        wr_vld = 1'b1;
        wr_key = s1_key;
        wr_val = s1_value;
        if (hop_here) begin
          addr   = h_evc[t];
          we     = 1'b1;
          wr_key = rd_key[PREV];
          wr_val = rd_val[PREV];
        end else if (s1_mod) begin
          addr = s1_addr[t];
          if (s1_cmd == CMD_DEL) begin
            we     = hit_vec[t];
            wr_vld = 1'b0;
          end else if (any_hit) begin
            we = hit_vec[t];
          end else begin
            we = (t == 0);
          end
        end
      end

      cuckoo_table #(.KEY_W(KEY_W), .VAL_W(VAL_W), .ADDR_W(ADDR_W)) i_table (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wr_vld(wr_vld),
        .wr_key(wr_key), .wr_val(wr_val),
        .rd_vld(rd_vld[t]), .rd_key(rd_key[t]), .rd_val(rd_val[t]));
    end
  endgenerate

  cuckoo_match #(.NUM_TBL(NUM_TBL), .KEY_W(KEY_W), .VAL_W(VAL_W)) i_match (
    .rd_vld(rd_vld), .rd_key(rd_key), .rd_val(rd_val), .key(s1_key),
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_val(hit_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_cmd     <= CMD_LOOK;
      s1_key     <= '0;
      s1_value   <= '0;
      s1_addr    <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_value  <= '0;
      chain_on   <= 1'b0;
      chain_tbl  <= '0;
      chain_hops <= '0;
      ovf_q      <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_cmd   <= cmd_e'(req_cmd);
        s1_key   <= req_key;
        s1_value <= req_value;
        s1_addr  <= h_req;
      end
      rsp_valid <= s1_valid;
      rsp_hit   <= s1_valid && any_hit;
      rsp_value <= (s1_valid && any_hit) ? hit_val : '0;

      if (s1_new_put) begin
        chain_on   <= 1'b1;
        chain_tbl  <= '0;
        chain_hops <= '0;
      end else if (chain_on) begin
        if (hop_go) begin
          chain_tbl  <= next_tbl;
          chain_hops <= chain_hops + 1'b1;
        end else begin
          chain_on <= 1'b0;
          if (hop_stop) ovf_q <= 1'b1;
        end
      end
    end
  end

  assign overflow = ovf_q;

  // R2: a response only follows an accepted request two cycles back
  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !busy, 2));

  // R8: an accepted modification closes the door on the next cycle
  p_busy_after_mod_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && (req_cmd == 2'd1 || req_cmd == 2'd2)) |=> busy);

  // R5: a key is never held by two tables
  p_unique_key_r5: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $onehot0(hit_vec));

  // R10: overflow is sticky
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10: the hop counter never passes its limit
  p_hops_bounded_r10: assert property (@(posedge clk) disable iff (rst)
    chain_hops <= HOP_W'(HOP_LIMIT));

  // R3: lookups alone never make the block busy
  p_lookup_no_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && (req_cmd == 2'd1 || req_cmd == 2'd2))) |=> !busy);
endmodule

// File: tb/test_cuckoo_kv_store.sv
module test_cuckoo_kv_store;
  localparam int NT = 4, KW = 16, VW = 16, AW = 4, HL = 24, DEP = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [KW-1:0] req_key = '0;
  logic [1:0] req_cmd = '0;
  logic [VW-1:0] req_value = '0;
  logic rsp_valid, rsp_hit, busy, overflow;
  logic [VW-1:0] rsp_value;

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference model of the four tables
  bit           mv [NT][DEP];
  logic [KW-1:0] mk [NT][DEP];
  logic [VW-1:0] mval [NT][DEP];
  bit           m_ovf;

  always #5 clk = ~clk;

  cuckoo_kv_store #(.NUM_TBL(NT), .KEY_W(KW), .VAL_W(VW), .ADDR_W(AW),
                    .HOP_LIMIT(HL)) i_cuckoo_kv_store (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_key(req_key),
    .req_cmd(req_cmd), .req_value(req_value), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_value(rsp_value), .busy(busy), .overflow(overflow));

  // R11 slot formula, written from the requirement
  function automatic logic [AW-1:0] hsh(int t, logic [KW-1:0] k);
    logic [63:0] s;
    logic [KW-1:0] r;
    s = 64'(t + 1) * 64'h9E3779B97F4A7C15;
    r = (t == 0) ? k : ((k << t) | (k >> (KW - t)));
    r = r ^ s[KW-1:0];
    return r[3:0] ^ r[7:4] ^ r[11:8] ^ r[15:12];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < NT; t++)
      for (int a = 0; a < DEP; a++) mv[t][a] = 0;
    m_ovf = 0;
  endtask

  task automatic model_apply(input logic [1:0] cmd, input logic [KW-1:0] k,
                             input logic [VW-1:0] v, output bit eh,
                             output logic [VW-1:0] ev, output int ebc);
    int ft;
    logic [KW-1:0] ck, tk;
    logic [VW-1:0] cv, tv;
    bit tvld;
    int t, hops;
    eh = 0; ev = '0; ft = -1;
    for (int i = 0; i < NT; i++)
      if (mv[i][hsh(i, k)] && mk[i][hsh(i, k)] == k) begin
        eh = 1; ev = mval[i][hsh(i, k)]; ft = i;
      end
    if (cmd == 2'd1) begin
      ebc = 1;
      if (ft >= 0) mv[ft][hsh(ft, k)] = 0;
    end else if (cmd == 2'd2) begin
      if (ft >= 0) begin
        ebc = 1;
        mval[ft][hsh(ft, k)] = v;
      end else begin
        ck = k; cv = v; t = 0; hops = 0;
        forever begin
          tvld = mv[t][hsh(t, ck)];
          tk   = mk[t][hsh(t, ck)];
          tv   = mval[t][hsh(t, ck)];
          mv[t][hsh(t, ck)] = 1; mk[t][hsh(t, ck)] = ck; mval[t][hsh(t, ck)] = cv;
          if (!tvld) break;
          if (hops == HL) begin m_ovf = 1; break; end
          ck = tk; cv = tv; t = (t + 1) % NT; hops++;
        end
        ebc = 2 + hops;
      end
    end else ebc = 0;
  endtask

  // One request through the block, checked against the model
  task automatic op(input logic [1:0] cmd, input logic [KW-1:0] k,
                    input logic [VW-1:0] v, input string req);
    bit eh; logic [VW-1:0] ev; int ebc, bc;
    model_apply(cmd, k, v, eh, ev, ebc);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_key = k; req_value = v;
    @(negedge clk);
    req_valid = 0;
    bc = busy ? 1 : 0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
    chk(rsp_hit == eh, req, "rsp_hit", rsp_hit, eh);
    chk(rsp_value == ev, req, "rsp_value", rsp_value, ev);
    while (busy) begin bc++; @(negedge clk); end
    chk(bc == ebc, req, "busy cycles", bc, ebc);
    chk(overflow == m_ovf, req, "overflow", overflow, m_ovf);
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    op(2'd0, 16'h0000, '0, "R1");
    op(2'd0, 16'h1234, '0, "R1");
  endtask

  task automatic t_insert_find();
    op(2'd2, 16'h0100, 16'hAAAA, "R4");
    op(2'd0, 16'h0100, '0, "R2");
    op(2'd2, 16'h0BEE, 16'h5555, "R4");
    op(2'd0, 16'h0BEE, '0, "R2");
    op(2'd3, 16'h0100, '0, "R3");
  endtask

  task automatic t_overwrite_delete();
    op(2'd2, 16'h0100, 16'hC0DE, "R6");
    op(2'd0, 16'h0100, '0, "R9");
    op(2'd1, 16'h0BEE, '0, "R7");
    op(2'd0, 16'h0BEE, '0, "R7");
    op(2'd1, 16'h7777, '0, "R7");
    op(2'd0, 16'h0100, '0, "R7");
  endtask

  // Keys sharing the table-0 slot force hops
  task automatic t_chain();
    logic [KW-1:0] base;
    int n;
    do_reset();
    base = 16'h4321; n = 0;
    op(2'd2, base, 16'h1000, "R5");
    for (int k = 1; k < 4000 && n < 6; k++)
      if (hsh(0, 16'(k)) == hsh(0, base) && 16'(k) != base) begin
        op(2'd2, 16'(k), 16'h2000 + 16'(n), "R5");
        n++;
      end
    op(2'd0, base, '0, "R5");
    for (int k = 1; k < 4000; k++)
      if (hsh(0, 16'(k)) == hsh(0, base) && k < 600) op(2'd0, 16'(k), '0, "R11");
  endtask

  task automatic t_busy_ignore();
    bit eh; logic [VW-1:0] ev; int ebc;
    model_apply(2'd2, 16'h0E0E, 16'h0E0E, eh, ev, ebc);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_cmd = 2'd2; req_key = 16'h0E0E; req_value = 16'h0E0E;
    @(negedge clk);
    chk(busy == 1, "R8", "busy", busy, 1);
    req_cmd = 2'd1; req_key = 16'h4321;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, "R8", "rsp_valid of put", rsp_valid, 1);
    @(negedge clk);
    chk(rsp_valid == 0, "R8", "rsp_valid of ignored", rsp_valid, 0);
    while (busy) @(negedge clk);
    op(2'd0, 16'h4321, '0, "R8");
    op(2'd0, 16'h0E0E, '0, "R8");
  endtask

  task automatic t_back_to_back();
    logic [KW-1:0] ks [3];
    bit eh; logic [VW-1:0] ev; int ebc;
    ks[0] = 16'h4321; ks[1] = 16'h9999; ks[2] = 16'h0E0E;
    @(negedge clk);
    while (busy) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (i >= 2) begin
        model_apply(2'd0, ks[i-2], '0, eh, ev, ebc);
        chk(rsp_valid == 1, "R3", "rsp_valid", rsp_valid, 1);
        chk(rsp_hit == eh && rsp_value == ev, "R3", "rsp", {rsp_hit, rsp_value}, {eh, ev});
      end
      chk(busy == 0, "R3", "busy", busy, 0);
      req_valid = (i < 3); req_cmd = 2'd0; req_key = (i < 3) ? ks[i] : '0;
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic t_fill_overflow();
    int i;
    do_reset();
    i = 0;
    while (!m_ovf && i < 200) begin
      op(2'd2, 16'(i * 37 + 5), 16'(i + 16'h300), "R10");
      i++;
    end
    chk(overflow == 1, "R10", "overflow set", overflow, 1);
    chk(busy == 0, "R10", "busy released", busy, 0);
    for (int j = 0; j < i; j++) op(2'd0, 16'(j * 37 + 5), '0, "R5");
    op(2'd1, 16'(5), '0, "R10");
    chk(overflow == 1, "R10", "overflow sticky", overflow, 1);
  endtask

  initial begin
    t_reset();
    t_insert_find();
    t_overwrite_delete();
    t_chain();
    t_busy_ignore();
    t_back_to_back();
    t_fill_overflow();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule